// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between a clocked system and an external asynchronous static RAM of 32K bytes that shares one bidirectional data bus for reads and writes. A requester hands over one byte-wide transfer at a time on a valid/ready handshake: an address, a write flag and, for writes, the byte to store. The controller then drives the active-low chip-enable, output-enable and write-enable strobes, holds the address, and controls the data pins through a split output / output-enable / input triple that the chip's pad ring joins into a tri-state pin.

Each strobe phase lasts a whole number of clock cycles. The cycle counts are derived at elaboration from the clock period and the memory's nanosecond limits, rounded up, with at least one cycle per phase. Read data comes back with a one-cycle valid pulse. After a read, the controller waits out the memory's bus-release time before it starts any new access. During a write, output-enable stays high, so only one side ever drives the shared bus.

Top module: `sram_port_ctrl`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of an access, leaves all three strobes high, the data drivers off, `req_ready` high and `rd_valid` low.
- R2: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access and any turnaround have finished.
- R3: A read holds chip-enable and output-enable low and write-enable high for RD = max(ceil(tRC/T), ceil(tAA/T), ceil(tOE/T)) cycles, which is 6 at the defaults (T = 10 ns, tRC = tAA = 55 ns, tOE = 30 ns). The address stays stable for as long as chip-enable is low.
- R4: The read byte is sampled on the last cycle of the read window. It appears on `rd_data` with `rd_valid` high for exactly one cycle, RD clock edges after the accepting edge.
- R5: A write runs as one setup cycle (chip-enable low, write-enable high), then a write-enable-low pulse, then one hold cycle (chip-enable low, write-enable high). Output-enable stays high for the whole write.
- R6: The write pulse lasts WP = max(ceil(tWP/T), ceil(tDW/T), ceil(tWC/T) - 2, 1) cycles, which is 4 at the defaults (tWP = 40 ns, tDW = 25 ns, tWC = 55 ns). A write therefore returns `req_ready` WP + 2 edges after acceptance (6 at the defaults).
- R7: The controller's data drivers are enabled only while write-enable is low. The driven byte equals the request's write data. Address and data do not change during the write.
- R8: After a read, chip-enable stays high for TA = max(1, ceil(tHZ/T)) cycles before `req_ready` returns, which is 2 at the defaults (tHZ = 20 ns).
- R9: While idle, all strobes are high (standby) and the data drivers are off.
- R10: The data drivers are never enabled while output-enable is low, nor within tHZ after the memory last drove the bus.
- R11: `rd_valid` never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 8 | Byte read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Address to the memory |
| mem_dq_out | output | 8 | Byte driven onto the data pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | 8 | Byte read from the data pins |

## Verification
A sequencer counter that runs short or long shows up at once as a read window, write pulse or turnaround of the wrong length. The bench's memory model measures each of these in clock cycles. A read window that is too short also returns corrupted data, because the model drives inverted bytes until its access time has elapsed, so the mismatch appears on the very next `rd_valid` pulse. A wrong strobe decode shows up within one cycle as overlapping drivers, output-enable low during a write, or strobes that are not high while `req_ready` is asserted. A lost write appears on the next read of the same address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } seq_st_t;

  // active-high view of the pin controls
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic drv;
  } pin_ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return imax(1, (ns + clk_ns - 1) / clk_ns);
  endfunction

  function automatic pin_ctl_t pin_ctl_of(input seq_st_t st);
    pin_ctl_t c;
    c = '0;
    case (st)
      ST_RD:   begin c.ce = 1'b1; c.oe = 1'b1; end
      ST_WSET: c.ce = 1'b1;
      ST_WPUL: begin c.ce = 1'b1; c.we = 1'b1; c.drv = 1'b1; end
      ST_WHLD: c.ce = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 4,
  parameter int TA_CYC = 2,
  localparam int CNT_W = $clog2(imax(imax(RD_CYC, WP_CYC), TA_CYC) + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    start_wr,
  output seq_st_t st_nxt,
  output logic    idle,
  output logic    capture
);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign idle     = (st_q == ST_IDLE);
  assign capture  = (st_q == ST_RD) && cnt_zero;

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_zero ? cnt_q : cnt_q - 1'b1;
    case (st_q)
      ST_IDLE: if (start) begin
        if (start_wr) begin
          st_nxt  = ST_WSET;
          cnt_nxt = '0;
        end else begin
          st_nxt  = ST_RD;
          cnt_nxt = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (cnt_zero) begin
        st_nxt  = ST_TURN;
        cnt_nxt = CNT_W'(TA_CYC - 1);
      end
      ST_TURN: if (cnt_zero) st_nxt = ST_IDLE;
      ST_WSET: begin
        st_nxt  = ST_WPUL;
        cnt_nxt = CNT_W'(WP_CYC - 1);
      end
      ST_WPUL: if (cnt_zero) st_nxt = ST_WHLD;
      ST_WHLD: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  // a counter loaded for a phase never exceeds that phase's length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WPUL) |-> (cnt_q <= CNT_W'(WP_CYC - 1)));
  p_turn_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    capture |=> (st_q == ST_TURN));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_st_t       st_nxt,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  pin_ctl_t ctl;
  assign ctl = pin_ctl_of(st_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      dq_oe  <= 1'b0;
      addr   <= '0;
      dq_out <= '0;
    end else begin
      ce_n  <= ~ctl.ce;
      oe_n  <= ~ctl.oe;
      we_n  <= ~ctl.we;
      dq_oe <= ctl.drv;
      if (accept) begin
        addr   <= req_addr;
        dq_out <= req_wdata;
      end
    end
  end

  p_we_excludes_oe_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && oe_n));
  p_drv_only_we_low_r7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !we_n);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(ns2cyc(T_RC_NS, CLK_NS),
                               imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
  localparam int WP_CYC = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)),
                               imax(ns2cyc(T_WC_NS, CLK_NS) - 2, 1));
  localparam int TA_CYC = ns2cyc(T_HZ_NS, CLK_NS);

  seq_st_t st_nxt;
  logic    idle, capture, accept;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (req_valid),
    .start_wr (req_write),
    .st_nxt   (st_nxt),
    .idle     (idle),
    .capture  (capture)
  );

  sram_pin_regs #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st_nxt    (st_nxt),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe)
  );

  sram_rd_capture #(
    .DW (DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  p_bus_free_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);
  p_idle_standby_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  p_no_valid_in_write_r11: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && mem_oe_n) |-> !rd_valid);

endmodule

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;

  localparam int CLK = 10;
  localparam int RD_EXP = 6;   // R3: max(ceil 55/10, ceil 55/10, ceil 30/10)
  localparam int WP_EXP = 4;   // R6: max(ceil 40/10, ceil 25/10, 6-2)
  localparam int WR_EXP = WP_EXP + 2;
  localparam int TA_EXP = 2;   // R8: ceil 20/10
  localparam int HZ_NS  = 20;
  localparam int RD_NEED = (55 + CLK - 1) / CLK - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int nchk = 0;
  int nfail = 0;
  int clash = 0;

  always #(CLK/2) clk = ~clk;

  sram_port_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] hi_of(input logic [7:0] lo);
    return 7'((int'(lo) * 37 + 11) % 128);
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int   lowcnt = 0;
  logic memdrv;
  assign memdrv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = memdrv ? ((lowcnt >= RD_NEED) ? mem[mem_addr[7:0]] : ~mem[mem_addr[7:0]])
                            : 8'h5A;

  always @(posedge clk) lowcnt <= memdrv ? lowcnt + 1 : 0;

  // write model and bus monitor
  int         wel = 0;
  logic       we_prev = 1'b1;
  logic [14:0] waddr;
  logic [7:0] wdat;
  time        last_drv = 0;
  bit         ever_drv = 0;
  always @(negedge clk) begin
    if (memdrv) begin last_drv = $time + CLK/2; ever_drv = 1; end
    if (mem_dq_oe && (memdrv || !mem_oe_n)) clash++;
    if (mem_dq_oe && ever_drv && ($time - last_drv) < HZ_NS) clash++;
    if (!rst) begin
      if (!mem_we_n) begin
        if (wel > 0 && (mem_addr != waddr || mem_dq_out != wdat)) clash++;
        wel++;
        waddr = mem_addr;
        wdat = mem_dq_out;
      end else if (!we_prev) begin
        chk(wel == WP_EXP, "R6 write pulse cycles", wel, WP_EXP);
        chk(waddr[14:8] == hi_of(waddr[7:0]), "R7 write address", waddr, {hi_of(waddr[7:0]), waddr[7:0]});
        mem[waddr[7:0]] = wdat;
        wel = 0;
      end
    end
    we_prev = mem_we_n;
  end

  // ---------------- access task ----------------
  task automatic do_op(input bit wr, input logic [7:0] lo, input logic [7:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {hi_of(lo), lo};
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R9 idle standby",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    if (wr) begin
      chk(!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R5 write setup",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0110);
      n = 0;
      while (!req_ready && n < 50) begin
        if (!mem_we_n) begin
          chk(mem_dq_oe && mem_dq_out == d, "R7 write data driven", {mem_dq_oe, mem_dq_out}, {1'b1, d});
          chk(mem_oe_n, "R5 oe high in write", mem_oe_n, 1);
        end
        chk(!rd_valid, "R11 no valid in write", rd_valid, 0);
        chk(mem_addr == {hi_of(lo), lo}, "R7 write address held", mem_addr, {hi_of(lo), lo});
        @(posedge clk); n++;
        @(negedge clk);
      end
      chk(n == WR_EXP, "R6 write length", n, WR_EXP);
      ref_mem[lo] = d;
    end else begin
      chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R3 read strobes",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      n = 0;
      while (!rd_valid && n < 50) begin
        chk(!mem_ce_n && !mem_oe_n && !req_ready, "R3 read window held",
            {mem_ce_n, mem_oe_n, req_ready}, 0);
        chk(mem_addr == {hi_of(lo), lo}, "R3 read address held", mem_addr, {hi_of(lo), lo});
        @(posedge clk); n++;
        @(negedge clk);
      end
      chk(n == RD_EXP, "R4 read latency", n, RD_EXP);
      chk(rd_data == ref_mem[lo], "R4 read data", rd_data, ref_mem[lo]);
      chk(mem_ce_n && mem_oe_n, "R8 strobes released", {mem_ce_n, mem_oe_n}, 2'b11);
      n = 0;
      while (!req_ready && n < 50) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (n == 1) chk(!rd_valid, "R4 single pulse", rd_valid, 0);
      end
      chk(n == TA_EXP, "R8 turnaround", n, TA_EXP);
    end
  endtask

  initial begin
    #(200_000 * CLK);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);
    rst = 1'b0;

    // directed corners
    do_op(1, 8'h00, 8'hFF);
    do_op(0, 8'h00, 8'h00);
    do_op(1, 8'hFF, 8'h00);
    do_op(0, 8'hFF, 8'h00);
    do_op(1, 8'h3C, 8'hA5);
    do_op(0, 8'h3C, 8'h00);
    do_op(1, 8'h3C, 8'h5A);   // write right after a read
    do_op(0, 8'h3C, 8'h00);

    // reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {hi_of(8'h10), 8'h10};
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1 reset mid access", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);
    rst = 1'b0;

    // constrained random traffic
    for (int k = 0; k < 300; k++) begin
      logic [7:0] lo, d;
      bit wr;
      lo = 8'($urandom % 16) * 8'd17;
      d  = 8'($urandom);
      wr = ($urandom % 2) == 1;
      do_op(wr, lo, d);
    end

    chk(clash == 0, "R10 bus contention or unstable write data", clash, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule